// File: doc/BRIEF.md
# Byte-Masked Single-Port RAM with Selectable Read-During-Write Behaviour

This block is a single-port synchronous RAM. It has one clock, one address and separate write and read enables. Each write carries a per-byte enable vector, so only the selected bytes of the addressed word are stored. Read data is registered and appears after the clock edge that samples the read.

A read and a write to the same address can fall on the same edge. An elaboration-time parameter then decides which word the read port returns. In old-data mode the port returns the word as it stood before the write, whatever the byte enables are. In new-data mode the output is built lane by lane. A lane whose byte enable is set shows the byte being written. A lane whose byte enable is clear shows the byte already held in the array. The result can therefore be a mix of fresh and stored bytes.

The block has no second port, no error correction, no extra output pipeline stage and no preload.

Top module: `masked_rdw_ram`

## Requirements
- R1: While `rst` is high at a clock edge, `rdata` becomes all zeros after that edge, in both modes.
- R2: `rdata` changes only after an edge where `rd_en` is 1. After an edge with `rd_en` 0 it keeps its previous value.
- R3: A read with `wr_en` 0 returns the whole word stored at `addr` after the edge.
- R4: MODE = 1 (new data), with `rd_en` and `wr_en` both 1 on the same edge: every lane i whose `byte_en[i]` is 1 shows `wdata[8i+7:8i]` on `rdata[8i+7:8i]` after that edge.
- R5: MODE = 1, same collision: every lane whose `byte_en` bit is 0 shows the byte stored before the edge. The output word is a lane-wise mix of new and stored bytes.
- R6: MODE = 0 (old data), same collision: `rdata` equals the whole word held at `addr` before the edge, whatever `byte_en` is.
- R7: A write with `wr_en` 1 stores lane i only if `byte_en[i]` is 1. Every other lane keeps its old contents, as a later read shows.
- R8: A write with `wr_en` 1 and `byte_en` all zeros changes nothing. A read on that edge returns the stored word in both modes.
- R9: With `wr_en` 0, the values on `byte_en` and `wdata` are ignored. The array and the output are the same as if they had been zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All activity happens on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. Clears the read register only. |
| addr | input | ADDR_W | Word address shared by the read and the write. |
| wr_en | input | 1 | Write request for this edge. |
| rd_en | input | 1 | Read request for this edge. Loads `rdata`. |
| byte_en | input | DATA_W/8 | Per-lane write enable. Bit i covers bits 8i+7..8i. |
| wdata | input | DATA_W | Write data. |
| rdata | output | DATA_W | Registered read data. |

## Verification
The write path and the read path can hit the same word on one edge, and that collision is the focus. The table drives same-address read-plus-write cycles with full, partial and empty byte enables. Two instances, one per mode, share the same inputs, so each mode's rule is checked against the same history. A random phase then keeps the address within four words. This makes collisions frequent and repeated. Every registered output is compared with a byte-level array model that applies the new-data or old-data rule before it applies the write.

// File: rtl/brw_pkg.sv
package brw_pkg;

    // Read-during-write behaviour selected at elaboration
    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_mode_e;

    localparam int LANE_W = 8;

    function automatic int lane_count(input int width);
        return width / LANE_W;
    endfunction

endpackage

// File: rtl/brw_lane_store.sv
// Byte-lane storage: one array per lane, written under its own enable,
// read combinationally (value before the current edge's write).
module brw_lane_store
    import brw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int LANES  = lane_count(DATA_W),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && byte_en[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign stored[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/brw_lane_merge.sv
// Builds the flow-through word: enabled lanes take write data,
// the rest keep the stored byte.
module brw_lane_merge
    import brw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = lane_count(DATA_W)
) (
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = (wr_en && byte_en[g])
                                            ? wdata[g*LANE_W +: LANE_W]
                                            : stored[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/brw_read_reg.sv
// Output register; the mode picks which word is captured on a read.
module brw_read_reg
    import brw_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter rdw_mode_e MODE   = RDW_NEW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] capture;

    if (MODE == RDW_NEW) begin : g_new
        assign capture = merged;
    end else begin : g_old
        assign capture = stored;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= capture;
        end
    end
endmodule

// File: rtl/masked_rdw_ram.sv
module masked_rdw_ram
    import brw_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter int        DEPTH  = 16,
    parameter rdw_mode_e MODE   = RDW_NEW,
    localparam int LANES  = lane_count(DATA_W),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] stored_word;
    logic [DATA_W-1:0] merged_word;

    brw_lane_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .addr   (addr),
        .wr_en  (wr_en),
        .byte_en(byte_en),
        .wdata  (wdata),
        .stored (stored_word)
    );

    brw_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .wr_en  (wr_en),
        .byte_en(byte_en),
        .wdata  (wdata),
        .stored (stored_word),
        .merged (merged_word)
    );

    brw_read_reg #(.DATA_W(DATA_W), .MODE(MODE)) u_rreg (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .stored(stored_word),
        .merged(merged_word),
        .rdata (rdata)
    );
endmodule

// File: rtl/masked_rdw_ram_chk.sv
module masked_rdw_ram_chk
    import brw_pkg::*;
#(
    parameter int        DATA_W = 32,
    parameter int        DEPTH  = 16,
    parameter rdw_mode_e MODE   = RDW_NEW,
    localparam int LANES  = lane_count(DATA_W),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [LANES-1:0]  byte_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bit_mask;
    logic              seen;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{byte_en[g]}};
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R1: reset clears the read register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> rdata == '0);

    // R2: no read, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R4: new-data collision passes enabled lanes
    a_r4_pass_lanes: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_NEW && rd_en && wr_en)
        |=> ((rdata ^ $past(wdata)) & $past(bit_mask)) == '0);

    // R6: old-data collision right after a plain read of the same word
    a_r6_old_word: assert property (@(posedge clk) disable iff (rst)
        (MODE == RDW_OLD && seen && rd_en && wr_en &&
         $past(rd_en) && !$past(wr_en) && $past(addr) == addr)
        |=> $stable(rdata));

    // R8: empty-mask write leaves the read equal to the stored word
    a_r8_empty_mask: assert property (@(posedge clk) disable iff (rst)
        (seen && rd_en && wr_en && byte_en == '0 &&
         $past(rd_en) && !$past(wr_en) && $past(addr) == addr)
        |=> $stable(rdata));
endmodule

bind masked_rdw_ram masked_rdw_ram_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(MODE)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .byte_en(byte_en),
    .wdata  (wdata),
    .rdata  (rdata)
);

// File: tb/masked_rdw_ram_test.sv
`timescale 1ns/1ps
module masked_rdw_ram_test;
    import brw_pkg::*;

    localparam int DW = 32;
    localparam int DP = 16;
    localparam int AW = 4;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [LN-1:0] byte_en = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_new;
    logic [DW-1:0] rdata_old;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    masked_rdw_ram #(.DATA_W(DW), .DEPTH(DP), .MODE(RDW_NEW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata_new)
    );

    masked_rdw_ram #(.DATA_W(DW), .DEPTH(DP), .MODE(RDW_OLD)) uut_old (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata_old)
    );

    typedef struct packed {
        logic          w;
        logic          r;
        logic [AW-1:0] a;
        logic [LN-1:0] be;
        logic [DW-1:0] wd;
        logic [DW-1:0] exp_new;
        logic [DW-1:0] exp_old;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 4'd3, 4'hF, 32'h11223344, 32'h00000000, 32'h00000000, 8'd2},
        '{1'b1, 1'b1, 4'd3, 4'h5, 32'hAABBCCDD, 32'h11BB33DD, 32'h11223344, 8'd5},
        '{1'b0, 1'b1, 4'd3, 4'hF, 32'hFFFFFFFF, 32'h11BB33DD, 32'h11BB33DD, 8'd7},
        '{1'b1, 1'b1, 4'd3, 4'h0, 32'h00000000, 32'h11BB33DD, 32'h11BB33DD, 8'd8},
        '{1'b1, 1'b0, 4'd5, 4'hF, 32'hCAFEF00D, 32'h11BB33DD, 32'h11BB33DD, 8'd2},
        '{1'b1, 1'b1, 4'd5, 4'hA, 32'h12345678, 32'h12FE560D, 32'hCAFEF00D, 8'd6},
        '{1'b1, 1'b1, 4'd5, 4'hF, 32'h0BADBEEF, 32'h0BADBEEF, 32'h12FE560D, 8'd4},
        '{1'b0, 1'b0, 4'd3, 4'hF, 32'hDEADBEEF, 32'h0BADBEEF, 32'h12FE560D, 8'd2},
        '{1'b0, 1'b1, 4'd3, 4'h0, 32'h00000000, 32'h11BB33DD, 32'h11BB33DD, 8'd9},
        '{1'b0, 1'b1, 4'd5, 4'h0, 32'h00000000, 32'h0BADBEEF, 32'h0BADBEEF, 8'd3}
    };

    // Byte-level model of the array
    logic [DW-1:0] model [DP];
    logic [DW-1:0] m_new;
    logic [DW-1:0] m_old;

    task automatic check(input string tag, input string which,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, which, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [AW-1:0] a,
                         input logic [LN-1:0] be, input logic [DW-1:0] wd);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; byte_en = be; wdata = wd;
        @(posedge clk);
        #1;
    endtask

    // Model one edge: outputs first (from the pre-write word), then the write
    task automatic model_step(input logic w, input logic r, input logic [AW-1:0] a,
                              input logic [LN-1:0] be, input logic [DW-1:0] wd);
        logic [DW-1:0] cur;
        logic [DW-1:0] mix;
        cur = model[a];
        mix = cur;
        for (int i = 0; i < LN; i++) begin
            if (w && be[i]) mix[i*8 +: 8] = wd[i*8 +: 8];
        end
        if (r) begin
            m_new = mix;
            m_old = cur;
        end
        if (w) model[a] = mix;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "new", rdata_new, '0);
        check("R1", "old", rdata_old, '0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].w, VEC[k].r, VEC[k].a, VEC[k].be, VEC[k].wd);
            check($sformatf("R%0d", VEC[k].req), "new", rdata_new, VEC[k].exp_new);
            check($sformatf("R%0d", VEC[k].req), "old", rdata_old, VEC[k].exp_old);
        end

        // Fill every word so the model is fully known
        for (int a = 0; a < DP; a++) begin
            logic [DW-1:0] v;
            v = {$urandom()};
            drive(1'b1, 1'b0, AW'(a), 4'hF, v);
            model[a] = v;
        end
        m_new = rdata_new;
        m_old = rdata_old;
        check("R2", "new", rdata_new, 32'h0BADBEEF);

        // Random phase, addresses folded onto four words for repeated collisions
        for (int n = 0; n < 3000; n++) begin
            logic          w;
            logic          r;
            logic [AW-1:0] a;
            logic [LN-1:0] be;
            logic [DW-1:0] wd;
            string         tn;
            string         to;
            w  = ($urandom_range(0, 3) != 0);
            r  = ($urandom_range(0, 3) != 0);
            a  = AW'($urandom_range(0, 3));
            be = LN'($urandom_range(0, 15));
            wd = {$urandom()};
            if (!r)          begin tn = "R2"; to = "R2"; end
            else if (!w)     begin tn = "R3"; to = "R3"; end
            else if (be == 0) begin tn = "R8"; to = "R8"; end
            else             begin tn = "R5"; to = "R6"; end
            model_step(w, r, a, be, wd);
            drive(w, r, a, be, wd);
            check(tn, "new", rdata_new, m_new);
            check(to, "old", rdata_old, m_old);
        end

        // R7: read back every folded word after the random writes
        for (int a = 0; a < 4; a++) begin
            model_step(1'b0, 1'b1, AW'(a), 4'h0, '0);
            drive(1'b0, 1'b1, AW'(a), 4'h0, '0);
            check("R7", "new", rdata_new, m_new);
            check("R7", "old", rdata_old, m_old);
        end

        // R1: reset in mid-run clears the output again
        @(negedge clk);
        rst = 1'b1;
        rd_en = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "new", rdata_new, '0);
        check("R1", "old", rdata_old, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule